// File: doc/BRIEF.md
# Masked Level Interrupt Combiner

The combiner merges a bank of level-sensitive interrupt inputs into one request line for a parent interrupt controller. Every input passes through a two-flop synchronizer. It is then gated by a per-source enable bit. The gated vector is readable as a status word, and its OR drives a registered request output. Source n always maps to bit n of every register.

Software changes the enable mask without a read-modify-write. One address turns on the enable bits that are written as ones. A second address turns off the enable bits that are written as ones. Zeros in the written word leave the matching bits as they were. After reset every source is disabled.

To service a request, the handler reads the status word and picks a source itself. A source drops out of the status once its input is released, so there is no acknowledge step.

Top module: `irq_merge_top`

## Requirements
- R1: While reset is active, and after it is released with no enable written, the enable mask reads 0, the status reads 0 and `irq_out` is 0, even with every input asserted.
- R2: A write to byte offset 0x0 sets each enable bit whose data bit is 1. Each enable bit whose data bit is 0 keeps its value.
- R3: A write to byte offset 0x4 clears each enable bit whose data bit is 1. Each enable bit whose data bit is 0 keeps its value.
- R4: A read of offset 0x0 or of offset 0x4 returns the current enable mask. Bit n is source n.
- R5: A read of offset 0xC returns the bitwise AND of the inputs and the enable mask. A change on `irq_raw` shows in the status two clock edges after it is sampled.
- R6: `irq_out` is the OR of the status bits, registered, so it follows the status one clock edge later.
- R7: Writes to offset 0xC and to any undefined offset leave the enable mask unchanged. Reads of undefined offsets return 0.
- R8: A status bit stays at 1 for as long as its input stays asserted and enabled, with no acknowledge access. It returns to 0 once the input is released.
- R9: Writing all ones to offset 0x4 disables every source, and `irq_out` falls one edge after that write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read strobe, 0 otherwise |
| irq_raw | input | 32 | Level-sensitive interrupt inputs |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
A register write takes effect at the clock edge that samples it. Mask read-back is therefore checked at the next falling edge. An input change passes two synchronizer flops, so the status is checked after two rising edges. The request output is checked after a third edge. The latency test samples at each intermediate falling edge, which confirms that the status has not moved after one edge and that the output is still low after two. All other checks wait three edges after a stimulus, then sample away from the rising edge. The expected value in each check is the product of a mask model in the bench and the pattern being driven.

// File: rtl/irq_merge_pkg.sv
`timescale 1ns/1ps
package irq_merge_pkg;
  localparam int unsigned OFS_ENA_ON  = 32'h0;
  localparam int unsigned OFS_ENA_OFF = 32'h4;
  localparam int unsigned OFS_PEND    = 32'hC;

  typedef enum logic [1:0] {SEL_NONE, SEL_ON, SEL_OFF, SEL_PEND} reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int unsigned ofs);
    if (ofs == OFS_ENA_ON)       return SEL_ON;
    else if (ofs == OFS_ENA_OFF) return SEL_OFF;
    else if (ofs == OFS_PEND)    return SEL_PEND;
    else                         return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_merge_sync.sv
`timescale 1ns/1ps
module irq_merge_sync #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_raw,
  output logic [N_SRC-1:0] irq_sync
);
  logic [STAGES-1:0][N_SRC-1:0] stage_q;
  logic [STAGES-1:0][N_SRC-1:0] stage_d;

  always_comb begin
    stage_d[0] = irq_raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      stage_d[s] = stage_q[s-1];
    end
    // R5
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign irq_sync = stage_q[STAGES-1];

  // R5
  stage_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage_q[0] == $past(irq_raw));
endmodule

// File: rtl/irq_merge_mask.sv
`timescale 1ns/1ps
module irq_merge_mask #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] on_vec,
  input  logic [N_SRC-1:0] off_vec,
  output logic [N_SRC-1:0] ena_mask
);
  logic [N_SRC-1:0] ena_q;
  logic [N_SRC-1:0] ena_d;
  logic             ena_upd;

  // off wins over on for the same bit
  always_comb begin
    ena_d   = (ena_q | on_vec) & ~off_vec;
    ena_upd = |(on_vec | off_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ena_q <= '0;
    else if (ena_upd) ena_q <= ena_d;
  end

  assign ena_mask = ena_q;

  // R2
  ena_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|on_vec && off_vec == '0) |=> (ena_q & $past(on_vec)) == $past(on_vec));
  // R3
  ena_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|off_vec) |=> (ena_q & $past(off_vec)) == '0);
  // R2
  ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((on_vec | off_vec) == '0) |=> $stable(ena_q));
endmodule

// File: rtl/irq_merge_regs.sv
`timescale 1ns/1ps
module irq_merge_regs
  import irq_merge_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  ena_mask,
  input  logic [N_SRC-1:0]  pend_vec,
  output logic [N_SRC-1:0]  on_vec,
  output logic [N_SRC-1:0]  off_vec,
  output logic [N_SRC-1:0]  bus_rdata
);
  reg_sel_e sel;
  logic     do_wr;
  logic     do_rd;

  always_comb begin
    sel       = decode_ofs(int'(bus_addr));
    do_wr     = bus_en & bus_we;
    do_rd     = bus_en & ~bus_we;
    on_vec    = (do_wr && sel == SEL_ON)  ? bus_wdata : '0;
    off_vec   = (do_wr && sel == SEL_OFF) ? bus_wdata : '0;
    bus_rdata = '0;
    if (do_rd) begin
      unique case (sel)
        SEL_ON, SEL_OFF: bus_rdata = ena_mask;
        SEL_PEND:        bus_rdata = pend_vec;
        default:         bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_merge_top.sv
`timescale 1ns/1ps
module irq_merge_top
  import irq_merge_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  irq_raw,
  output logic              irq_out
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [N_SRC-1:0]      irq_sync;
  logic [N_SRC-1:0]      ena_mask;
  logic [N_SRC-1:0]      pend_vec;
  logic [N_SRC-1:0]      on_vec;
  logic [N_SRC-1:0]      off_vec;
  logic                  out_q;
  logic                  out_d;
  logic                  out_upd;

  // reset: asserted at once, released after RST_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  irq_merge_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .irq_raw  (irq_raw),
    .irq_sync (irq_sync)
  );

  irq_merge_mask #(.N_SRC(N_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .on_vec   (on_vec),
    .off_vec  (off_vec),
    .ena_mask (ena_mask)
  );

  irq_merge_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ena_mask  (ena_mask),
    .pend_vec  (pend_vec),
    .on_vec    (on_vec),
    .off_vec   (off_vec),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    pend_vec = irq_sync & ena_mask;
    out_d    = |pend_vec;
    out_upd  = out_d ^ out_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   out_q <= 1'b0;
    else if (out_upd) out_q <= out_d;
  end

  assign irq_out = out_q;

  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> irq_out == $past(|(irq_sync & ena_mask)));
  // R7
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en && bus_we && decode_ofs(int'(bus_addr)) != SEL_ON &&
     decode_ofs(int'(bus_addr)) != SEL_OFF) |=> $stable(ena_mask));
  // R9
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en && bus_we && decode_ofs(int'(bus_addr)) == SEL_OFF && &bus_wdata)
    |=> ena_mask == '0);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (irq_out == 1'b0 && ena_mask == '0));
endmodule

// File: tb/test_irq_merge_top.sv
`timescale 1ns/1ps
module test_irq_merge_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [3:0]    bus_addr;
  logic [N-1:0]  bus_wdata, bus_rdata, irq_raw;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [N-1:0] exp_mask;

  always #2.5 clk = ~clk;

  irq_merge_top i_irq_merge_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_raw(irq_raw), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
    #0.1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_status(input string req);
    logic [N-1:0] v;
    rd(4'hC, v);
    chk(req, v, irq_raw & exp_mask);
    chk(req, {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, |(irq_raw & exp_mask)});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] lcg;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_raw = '1; exp_mask = '0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk("R1 out in reset", {31'b0, irq_out}, '0);
    rd(4'h0, v); chk("R1 mask in reset", v, '0);
    rd(4'hC, v); chk("R1 status in reset", v, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'h0, v); chk("R1 mask after reset", v, '0);
    rd(4'hC, v); chk("R1 status after reset", v, '0);
    chk("R1 out after reset", {31'b0, irq_out}, '0);
    irq_raw = '0;

    // R2 and R4: walk each set bit
    for (int i = 0; i < N; i++) begin
      wr(4'h0, N'(1) << i);
      exp_mask |= N'(1) << i;
      rd(4'h0, v); chk("R2 set walk", v, exp_mask);
      rd(4'h4, v); chk("R4 read via off offset", v, exp_mask);
    end
    wr(4'h0, '0);
    rd(4'h0, v); chk("R2 zero write keeps", v, exp_mask);

    // R3: clear even bits one at a time
    for (int i = 0; i < N; i += 2) begin
      wr(4'h4, N'(1) << i);
      exp_mask &= ~(N'(1) << i);
      rd(4'h4, v); chk("R3 clear walk", v, exp_mask);
    end
    wr(4'h4, '0);
    rd(4'h0, v); chk("R3 zero write keeps", v, exp_mask);

    // R7: every other offset is ignored on write, reads zero
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) begin
        wr(4'(a), '1);
        rd(4'h0, v); chk("R7 write ignored", v, exp_mask);
        wr(4'(a), '0);
        rd(4'h4, v); chk("R7 zero write ignored", v, exp_mask);
        if (a != 12) begin
          rd(4'(a), v); chk("R7 undefined read zero", v, '0);
        end
      end
    end

    // R5, R6: walking inputs against odd-bit mask
    for (int i = 0; i < N; i++) begin
      @(negedge clk); irq_raw = N'(1) << i;
      settle();
      chk_status("R5 R6 walk");
    end
    // R5, R6: computed patterns with changing masks
    lcg = 32'h1234_5678;
    for (int k = 0; k < 24; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (k % 3 == 0) begin
        wr(4'h0, lcg ^ 32'h5A5A_0F0F);
        exp_mask |= lcg ^ 32'h5A5A_0F0F;
      end else if (k % 3 == 1) begin
        wr(4'h4, lcg);
        exp_mask &= ~lcg;
      end
      @(negedge clk); irq_raw = (k % 5 == 0) ? '0 : lcg;
      settle();
      chk_status("R5 R6 pattern");
    end

    // R5, R6: per-edge latency
    wr(4'h4, '1); wr(4'h0, 32'h0000_0002); exp_mask = 32'h0000_0002;
    @(negedge clk); irq_raw = '0;
    settle();
    irq_raw = 32'h0000_0002;
    @(negedge clk);
    rd(4'hC, v); chk("R5 status not after one edge", v, '0);
    @(negedge clk);
    rd(4'hC, v); chk("R5 status after two edges", v, 32'h2);
    chk("R6 out low after two edges", {31'b0, irq_out}, '0);
    @(negedge clk);
    chk("R6 out high after three edges", {31'b0, irq_out}, 32'h1);

    // R8: level held with no acknowledge, then released
    repeat (10) @(negedge clk);
    rd(4'hC, v); chk("R8 status held", v, 32'h2);
    chk("R8 out held", {31'b0, irq_out}, 32'h1);
    irq_raw = '0;
    @(negedge clk); @(negedge clk);
    rd(4'hC, v); chk("R8 status released", v, '0);
    @(negedge clk);
    chk("R8 out released", {31'b0, irq_out}, '0);

    // R9: clear all disables everything
    irq_raw = '1;
    wr(4'h0, '1); exp_mask = '1;
    settle();
    chk_status("R9 all enabled");
    wr(4'h4, '1); exp_mask = '0;
    rd(4'h0, v); chk("R9 mask zero", v, '0);
    rd(4'hC, v); chk("R9 status zero", v, '0);
    @(negedge clk);
    chk("R9 out dropped", {31'b0, irq_out}, '0);

    done = 1;
    summary();
    $finish;
  end
endmodule